// File: doc/BRIEF.md
# Two-Rank Refresh-Aware Command Scheduler

This block sits in front of two DRAM ranks that share a single command and data bus, each rank selected by its own chip-select line. Memory requests arrive on a valid/ready port, each tagged with the rank it targets, a read/write flag and an address. The block issues at most one command per cycle on the shared bus, with exactly one chip select active for a real command.

Each rank has its own refresh timer, set as a cycle count parameter. When a rank's timer comes within a small margin of expiry, a refresh command is issued to that rank ahead of any request. The rank then stays busy for a fixed number of cycles. While one rank is busy, queued work for the other rank goes ahead, even when it arrived later than the blocked work. When both ranks can take work, requests leave in arrival order. Requests to the same rank never overtake one another.

Top module: `rank_refresh_sched`

## Requirements
- R1: In every cycle at most one bit of `cmd_cs` is high. `cmd_cs[0]` selects rank 0 and `cmd_cs[1]` selects rank 1. `cmd_op` is 0 (idle) exactly when `cmd_cs` is all zero. The other codes are 1 read, 2 write and 3 refresh.
- R2: While reset is asserted, `cmd_cs` is 0, `cmd_op` is idle and `req_ready` is 1.
- R3: The read/write commands to a rank carry the address and the read/write kind of the accepted requests for that rank, in the order those requests were accepted.
- R4: Every accepted request is issued exactly once.
- R5: Refresh commands to the same rank are spaced by at least `REF_INTERVAL-REF_MARGIN` and at most `REF_INTERVAL` cycles. A due refresh outranks all queued requests.
- R6: No read or write reaches a rank within `BUSY_CYCLES` cycles after that rank's refresh command.
- R7: While one rank is busy, a queued request for the other rank is issued even if an older request for the busy rank is waiting.
- R8: When both ranks can accept a request, the one accepted earlier is issued first.
- R9: When both ranks are due for refresh in the same cycle, a round-robin pointer picks the rank to refresh first. The pointer starts at rank 0 after reset and toggles after each such tie.
- R10: `req_ready` is low exactly when the queue of the rank named by `req_dev` holds `DEPTH` requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is taken at this clock edge |
| req_dev | input | 1 | Target rank of the request |
| req_wr | input | 1 | 1 means write, 0 means read |
| req_addr | input | AW | Request address |
| cmd_cs | output | 2 | Chip-select vector, one bit per rank |
| cmd_op | output | 2 | Command code: 0 idle, 1 read, 2 write, 3 refresh |
| cmd_addr | output | AW | Address of a read or write command, zero for a refresh |

## Verification
Just after reset, both timers expire together. The bench queues a rank-1 request followed by two rank-0 requests while both ranks are busy. Rank 0 is freed one cycle earlier, so the correct result is the rank-0 head first, then the older rank-1 request, then the second rank-0 request. A design without bypass would stall on the oldest request. A design with a fixed rank priority would send both rank-0 requests first. The bench also fills one rank's queue during its busy window to check that back-pressure applies per rank. A long run of random traffic then checks per-rank order, refresh spacing and the busy window after every refresh. That run catches a scheduler that lets requests starve a refresh or touch a rank that is still recovering.

// File: rtl/rrs_pkg.sv
`timescale 1ns/1ps
package rrs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_REF  = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/rrs_queue.sv
`timescale 1ns/1ps
// Per-rank request FIFO; storage has no reset, pointers do.
module rrs_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? adv(wp_q) : wp_q;
    rp_d  = pop  ? adv(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/rrs_refresh_timer.sv
`timescale 1ns/1ps
// Per-rank refresh countdown and post-refresh busy window.
module rrs_refresh_timer #(
  parameter int REF_INTERVAL = 1000,
  parameter int REF_MARGIN   = 4,
  parameter int BUSY_CYCLES  = 10,
  localparam int LW = $clog2(REF_INTERVAL + 1),
  localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_issue,
  output logic          due,
  output logic          busy,
  output logic [LW-1:0] left
);
  logic [LW-1:0] left_q, left_d;
  logic [BW-1:0] busy_q, busy_d;

  always_comb begin
    left_d = left_q;
    busy_d = busy_q;
    if (ref_issue) begin
      left_d = LW'(REF_INTERVAL);
      busy_d = BW'(BUSY_CYCLES);
    end else begin
      if (left_q != '0) left_d = left_q - 1'b1;
      if (busy_q != '0) busy_d = busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= LW'(REF_INTERVAL);
      busy_q <= '0;
    end else begin
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign due  = (left_q <= LW'(REF_MARGIN));
  assign busy = (busy_q != '0);
  assign left = left_q;
endmodule

// File: rtl/rrs_arbiter.sv
`timescale 1ns/1ps
// Picks one command per cycle: due refresh first, then requests.
module rrs_arbiter (
  input  logic [1:0] due,
  input  logic [1:0] busy,
  input  logic [1:0] has_req,
  input  logic       older0,
  input  logic       rr,
  output logic       gnt_valid,
  output logic       gnt_ref,
  output logic       gnt_dev,
  output logic       tie_ref
);
  logic [1:0] ref_ok, elig;

  always_comb begin
    ref_ok    = due & ~busy;
    elig      = has_req & ~busy & ~due;
    gnt_valid = 1'b0;
    gnt_ref   = 1'b0;
    gnt_dev   = 1'b0;
    tie_ref   = 1'b0;
    if (&ref_ok) begin
      gnt_valid = 1'b1;
      gnt_ref   = 1'b1;
      gnt_dev   = rr;
      tie_ref   = 1'b1;
    end else if (|ref_ok) begin
      gnt_valid = 1'b1;
      gnt_ref   = 1'b1;
      gnt_dev   = ref_ok[1];
    end else if (&elig) begin
      gnt_valid = 1'b1;
      gnt_dev   = ~older0;
    end else if (|elig) begin
      gnt_valid = 1'b1;
      gnt_dev   = elig[1];
    end
  end
endmodule

// File: rtl/rank_refresh_sched.sv
`timescale 1ns/1ps
module rank_refresh_sched
  import rrs_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int AW           = 32,
  parameter int REF_INTERVAL = 16_000_000,
  parameter int REF_MARGIN   = 8,
  parameter int BUSY_CYCLES  = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_dev,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  output logic [1:0]    cmd_cs,
  output logic [1:0]    cmd_op,
  output logic [AW-1:0] cmd_addr
);
  localparam int SW = $clog2(2 * DEPTH) + 1;
  localparam int EW = SW + 1 + AW;
  localparam int LW = $clog2(REF_INTERVAL + 1);

  logic [1:0]          q_full, q_empty, push, pop, due, busy_vec, ref_issue;
  logic [1:0][EW-1:0]  head;
  logic [1:0][LW-1:0]  ref_left;
  logic [SW-1:0]       stamp_q, stamp_d, sdiff;
  logic                rr_q, rr_d;
  logic                gnt_valid, gnt_ref, gnt_dev, tie_ref, older0;
  logic [1:0]          cs_q, cs_d;
  cmd_op_e             op_q, op_d;
  logic [AW-1:0]       addr_q, addr_d;

  assign req_ready = ~q_full[req_dev];

  // wrap-safe age compare of the two queue heads
  assign sdiff  = head[0][EW-1 -: SW] - head[1][EW-1 -: SW];
  assign older0 = sdiff[SW-1];

  for (genvar d = 0; d < 2; d++) begin : g_rank
    assign push[d]      = req_valid & req_ready & (req_dev == 1'(d));
    assign pop[d]       = gnt_valid & ~gnt_ref & (gnt_dev == 1'(d));
    assign ref_issue[d] = gnt_valid &  gnt_ref & (gnt_dev == 1'(d));

    rrs_queue #(.DEPTH(DEPTH), .W(EW)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push[d]),
      .din  ({stamp_q, req_wr, req_addr}),
      .pop  (pop[d]),
      .dout (head[d]),
      .full (q_full[d]),
      .empty(q_empty[d])
    );

    rrs_refresh_timer #(
      .REF_INTERVAL(REF_INTERVAL),
      .REF_MARGIN  (REF_MARGIN),
      .BUSY_CYCLES (BUSY_CYCLES)
    ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_issue(ref_issue[d]),
      .due      (due[d]),
      .busy     (busy_vec[d]),
      .left     (ref_left[d])
    );
  end

  rrs_arbiter u_arb (
    .due      (due),
    .busy     (busy_vec),
    .has_req  (~q_empty),
    .older0   (older0),
    .rr       (rr_q),
    .gnt_valid(gnt_valid),
    .gnt_ref  (gnt_ref),
    .gnt_dev  (gnt_dev),
    .tie_ref  (tie_ref)
  );

  always_comb begin
    stamp_d = (|push) ? stamp_q + 1'b1 : stamp_q;
    rr_d    = tie_ref ? ~rr_q : rr_q;
    cs_d    = '0;
    op_d    = OP_IDLE;
    addr_d  = '0;
    if (gnt_valid) begin
      cs_d[gnt_dev] = 1'b1;
      if (gnt_ref) begin
        op_d = OP_REF;
      end else begin
        op_d   = head[gnt_dev][AW] ? OP_WR : OP_RD;
        addr_d = head[gnt_dev][AW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      rr_q    <= 1'b0;
      cs_q    <= '0;
      op_q    <= OP_IDLE;
      addr_q  <= '0;
    end else begin
      stamp_q <= stamp_d;
      rr_q    <= rr_d;
      cs_q    <= cs_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
    end
  end

  assign cmd_cs   = cs_q;
  assign cmd_op   = op_q;
  assign cmd_addr = addr_q;
endmodule

// File: rtl/rrs_checker.sv
`timescale 1ns/1ps
module rrs_checker #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cmd_cs,
  input logic [1:0]    cmd_op,
  input logic [LW-1:0] left0,
  input logic [LW-1:0] left1,
  input logic [1:0]    busy
);
  a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_cs));

  a_r1_idle_iff_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd0) == (cmd_cs == 2'b00));

  a_r5_rank0_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
    left0 != '0);

  a_r5_rank1_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
    left1 != '0);

  a_r6_rank0_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cs[0] && (cmd_op == 2'd1 || cmd_op == 2'd2)) |-> !$past(busy[0]));

  a_r6_rank1_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cs[1] && (cmd_op == 2'd1 || cmd_op == 2'd2)) |-> !$past(busy[1]));
endmodule

bind rank_refresh_sched rrs_checker #(.LW(LW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cmd_cs(cmd_cs),
  .cmd_op(cmd_op),
  .left0 (ref_left[0]),
  .left1 (ref_left[1]),
  .busy  (busy_vec)
);

// File: tb/rank_refresh_sched_test.sv
`timescale 1ns/1ps
module rank_refresh_sched_test;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int RI    = 200;
  localparam int MRG   = 4;
  localparam int BUSY  = 12;

  typedef struct packed {
    logic          dev;
    logic [1:0]    op;
    logic [AW-1:0] addr;
  } ev_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_dev, req_wr;
  logic [AW-1:0] req_addr;
  logic [1:0]    cmd_cs, cmd_op;
  logic [AW-1:0] cmd_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int accepted = 0;
  int issued   = 0;
  int nref [2];
  int last_ref [2];
  bit seen_ref [2];
  logic [AW:0] expq0 [$];
  logic [AW:0] expq1 [$];
  ev_t log_q [$];

  always #2 clk = ~clk;

  rank_refresh_sched #(
    .DEPTH(DEPTH), .AW(AW), .REF_INTERVAL(RI),
    .REF_MARGIN(MRG), .BUSY_CYCLES(BUSY)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_wr(req_wr), .req_addr(req_addr),
    .cmd_cs(cmd_cs), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Offer one request for one cycle; record it as expected when taken.
  task automatic drive(input logic dev, input logic wr, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev; req_wr = wr; req_addr = a;
    #0.5;
    if (req_ready) begin
      accepted++;
      if (dev) expq1.push_back({wr, a});
      else     expq0.push_back({wr, a});
    end
    @(posedge clk);
    #0.5 req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk($onehot0(cmd_cs), "R1", "cs onehot", cmd_cs, 1);
      chk((cmd_op == 2'd0) == (cmd_cs == 2'b00), "R1", "op vs cs", cmd_op, cmd_cs);
      if (cmd_cs != 2'b00) begin
        logic d;
        d = cmd_cs[1];
        log_q.push_back('{dev: d, op: cmd_op, addr: cmd_addr});
        if (cmd_op == 2'd3) begin
          if (seen_ref[d])
            chk((cyc - last_ref[d] <= RI) && (cyc - last_ref[d] >= RI - MRG),
                "R5", "refresh spacing", cyc - last_ref[d], RI);
          else
            chk(cyc <= RI + 2, "R5", "first refresh", cyc, RI);
          seen_ref[d] = 1'b1;
          last_ref[d] = cyc;
          nref[d]++;
        end else begin
          logic [AW:0] got, exp;
          issued++;
          got = {cmd_op == 2'd2, cmd_addr};
          if (seen_ref[d])
            chk(cyc - last_ref[d] > BUSY, "R6", "access in busy window",
                cyc - last_ref[d], BUSY + 1);
          if (d ? (expq1.size() == 0) : (expq0.size() == 0)) begin
            chk(1'b0, "R3", "unexpected command", got, 0);
          end else begin
            exp = d ? expq1.pop_front() : expq0.pop_front();
            chk(got == exp, "R3", "per-rank order/content", got, exp);
          end
        end
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    nref[0] = 0; nref[1] = 0;
    seen_ref[0] = 1'b0; seen_ref[1] = 1'b0;
    req_valid = 1'b0; req_dev = 1'b0; req_wr = 1'b0; req_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_cs == 2'b00, "R2", "cs in reset", cmd_cs, 0);
    chk(cmd_op == 2'd0,  "R2", "op in reset", cmd_op, 0);
    chk(req_ready == 1'b1, "R2", "ready in reset", req_ready, 1);
    rst_n = 1'b1;

    // Tie at first expiry, then bypass and arrival order
    wait (nref[1] >= 1);
    chk(log_q.size() == 2, "R9", "refresh count", log_q.size(), 2);
    if (log_q.size() == 2) begin
      chk(log_q[0].dev == 1'b0 && log_q[0].op == 2'd3, "R9", "first refresh rank",
          log_q[0].dev, 0);
      chk(log_q[1].dev == 1'b1 && log_q[1].op == 2'd3, "R9", "second refresh rank",
          log_q[1].dev, 1);
    end
    log_q.delete();
    drive(1'b1, 1'b0, 16'h0111);
    drive(1'b0, 1'b1, 16'h0222);
    drive(1'b0, 1'b0, 16'h0333);
    repeat (40) @(posedge clk);
    chk(log_q.size() == 3, "R7", "issued count", log_q.size(), 3);
    if (log_q.size() == 3) begin
      chk(log_q[0].addr == 16'h0222, "R7", "free rank bypasses older", log_q[0].addr, 16'h0222);
      chk(log_q[1].addr == 16'h0111, "R8", "older goes next", log_q[1].addr, 16'h0111);
      chk(log_q[2].addr == 16'h0333, "R8", "younger last", log_q[2].addr, 16'h0333);
    end

    // Per-rank back-pressure during rank 0 busy window
    begin
      int n0;
      n0 = nref[0];
      wait (nref[0] > n0);
    end
    for (int i = 0; i < DEPTH; i++) drive(1'b0, 1'b1, AW'(16'h0A00 + i));
    @(negedge clk);
    req_dev = 1'b0; #0.5;
    chk(req_ready == 1'b0, "R10", "full rank not ready", req_ready, 0);
    req_dev = 1'b1; #0.5;
    chk(req_ready == 1'b1, "R10", "other rank ready", req_ready, 1);
    repeat (30) @(posedge clk);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(1, 0) == 1)
        drive(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), AW'($urandom));
      else
        @(posedge clk);
    end
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(expq0.size() == 0 && expq1.size() == 0, "R4", "queues drained",
        expq0.size() + expq1.size(), 0);
    chk(issued == accepted, "R4", "issued count", issued, accepted);
    chk(cyc - last_ref[0] <= RI, "R5", "rank0 refresh age", cyc - last_ref[0], RI);
    chk(cyc - last_ref[1] <= RI, "R5", "rank1 refresh age", cyc - last_ref[1], RI);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule